// File: doc/BRIEF.md
# DVMA Address Translator with Fault Capture

This block turns a virtual address issued by a DMA-capable device into a 36-bit physical address. For an ordinary translation it computes where the matching I/O page-table entry lives, fetches that one 32-bit entry over a request/response port, checks the entry, and combines the page number from the entry with the untouched page offset. The mapped window starts at an address that the surrounding register block supplies. The page-table base comes from the register block too.

Each requesting slot can be set to skip translation entirely. In that case the device address is used as the physical address, and a per-slot option forces physical bit 30 high. A translation fails when:
- the address lies below the window start,
- the fetched entry is not valid, or
- a write targets a page that is not writable.

A failed translation is logged in a fault status word and a fault address word.

Only one request is in flight at a time. The result stays on the outputs until the requester acknowledges it.

Top module: `dvma_xlate`

## Requirements
- R1: For a translated access with a usable entry, the physical address is entry bits [31:8] placed at physical bits [35:12], with virtual bits [11:0] copied unchanged into physical bits [11:0]. The error flag is low.
- R2: The entry fetch address equals the page-table base plus four times the page index. The page index is (virtual address minus window start) shifted right by 12.
- R3: Entry bit 7 (cacheable hint) appears on the cache output of a successful translation.
- R4: An entry with bit 1 (valid) clear gives a result with the error flag high and a physical address of zero.
- R5: A write to an entry with bit 2 (writable) clear is an error. A read of the same entry succeeds.
- R6: An address below the window start is an error, and no entry is fetched.
- R7: For a slot whose bypass bit is set, no entry is fetched and no error is raised, even below the window. The physical address is the zero-extended virtual address, ORed with bit 30 when that slot's bit-30 option is set.
- R8: A fault while fault status bit 17 is clear sets the status to 0xC0820000, with bit 18 added (0xC0860000) for a read. The full virtual address is captured.
- R9: A fault while status bit 17 is already set only adds bit 19. The other status bits and the captured address are kept.
- R10: After reset the fault status is 0x00800000, the fault address is zero, the block is ready for a request and no result is shown. Status bit 23 never clears.
- R11: While a result is shown, the block refuses new requests. The result, its flags and its address stay steady until the acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | 32 | Device virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_slot | input | 2 | Requesting slot number |
| win_start | input | 32 | Start address of the mapped window |
| pt_base | input | 32 | Page-table base address |
| slot_bypass | input | 4 | Per-slot bypass enables |
| slot_hi30 | input | 4 | Per-slot physical bit 30 for bypass |
| pte_req_valid | output | 1 | Entry fetch request |
| pte_req_ready | input | 1 | Entry fetch accepted |
| pte_req_addr | output | 32 | Entry fetch address |
| pte_rsp_valid | input | 1 | Entry data returned |
| pte_rsp_data | input | 32 | Entry data |
| rsp_done | output | 1 | Result available |
| rsp_err | output | 1 | Result is a fault |
| rsp_pa | output | 36 | Physical address (zero on fault) |
| rsp_cache | output | 1 | Cacheable hint of the result |
| rsp_ack | input | 1 | Requester takes the result |
| fault_status | output | 32 | Fault status word |
| fault_addr | output | 32 | Captured faulting virtual address |

## Verification
The bench sweeps sixteen consecutive pages of two window sizes, with a read and a write on each page, and a page offset that changes from page to page. This separates offset pass-through from page-number placement and fetch-address arithmetic. The entries in the bench's table cycle through valid, invalid, writable and read-only combinations, and through both values of the cacheable hint. The same page therefore tells a permission fault apart from a validity fault, and a read apart from a write. Addresses just below the window are sent from both bypassed and translated slots, which shows that bypass takes priority over the window check. Bypass is also tried with and without the bit-30 option. Fault words are tracked across the whole sweep, so the first-fault encoding and the multiple-error marking are both observed. Acknowledgement is also held back over several cycles, with a competing request present at the same time.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
   // Fault status bit positions (decoded by software, kept fixed)
   localparam int FS_ERR  = 31;
   localparam int FS_LE   = 30;
   localparam int FS_RSV  = 23;
   localparam int FS_ME   = 19;
   localparam int FS_RD   = 18;
   localparam int FS_FAV  = 17;

   // Entry flag positions
   localparam int PTE_VALID_BIT = 1;
   localparam int PTE_WR_BIT    = 2;
   localparam int PTE_CACHE_BIT = 7;

   typedef enum logic [1:0] {
      XS_IDLE  = 2'd0,
      XS_FETCH = 2'd1,
      XS_WAIT  = 2'd2,
      XS_DONE  = 2'd3
   } xlate_state_e;
endpackage

// File: rtl/dvma_win_decode.sv
module dvma_win_decode #(
   parameter int VA_W       = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int PTE_BYTES  = 4
) (
   input  logic [VA_W-1:0] addr,
   input  logic [VA_W-1:0] win_start,
   input  logic [VA_W-1:0] pt_base,
   output logic            in_window,
   output logic [VA_W-1:0] pte_addr
);
   localparam int ENT_SHIFT = $clog2(PTE_BYTES);

   logic [VA_W-1:0] delta;
   logic [VA_W-1:0] page_idx;

   always_comb begin
      in_window = (addr >= win_start);
      delta     = addr - win_start;
      page_idx  = delta >> PAGE_SHIFT;
      pte_addr  = pt_base + (page_idx << ENT_SHIFT);
   end
endmodule

// File: rtl/dvma_pte_eval.sv
module dvma_pte_eval
   import dvma_pkg::*;
#(
   parameter int PA_W       = 36,
   parameter int PTE_W      = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic [PTE_W-1:0]      pte,
   input  logic [PAGE_SHIFT-1:0] offset,
   input  logic                  is_write,
   output logic                  ok,
   output logic [PA_W-1:0]       pa,
   output logic                  cache
);
   localparam int PPN_W   = PA_W - PAGE_SHIFT;
   localparam int PPN_LSB = PTE_W - PPN_W;

   logic valid_f;
   logic wr_f;

   always_comb begin
      valid_f = pte[PTE_VALID_BIT];
      wr_f    = pte[PTE_WR_BIT];
      ok      = valid_f && (!is_write || wr_f);
      pa      = ok ? {pte[PTE_W-1:PPN_LSB], offset} : '0;
      cache   = ok && pte[PTE_CACHE_BIT];
   end
endmodule

// File: rtl/dvma_bypass_sel.sv
module dvma_bypass_sel #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 36,
   parameter int NSLOT     = 4,
   parameter int HI_BIT    = 30,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic [VA_W-1:0]          addr,
   input  logic [$clog2(NSLOT)-1:0] slot,
   input  logic [NSLOT-1:0]         bypass_en,
   input  logic [NSLOT-1:0]         hi_en,
   output logic                     hit,
   output logic [PA_W-1:0]          pa
);
   localparam int EXT_W = PA_W - VA_W;

   generate
      if (BYPASS_EN) begin : g_bypass
         logic [PA_W-1:0] hi_mask;
         always_comb begin
            hi_mask         = '0;
            hi_mask[HI_BIT] = hi_en[slot];
            hit             = bypass_en[slot];
            pa              = {{EXT_W{1'b0}}, addr} | hi_mask;
         end
      end else begin : g_nobypass
         logic unused_ok;
         always_comb begin
            hit       = 1'b0;
            pa        = '0;
            unused_ok = ^{addr, slot, bypass_en, hi_en};
         end
      end
   endgenerate
endmodule

// File: rtl/dvma_fault_log.sv
module dvma_fault_log
   import dvma_pkg::*;
#(
   parameter int VA_W = 32,
   parameter int FS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            log_en,
   input  logic            log_read,
   input  logic [VA_W-1:0] log_addr,
   output logic [FS_W-1:0] status,
   output logic [VA_W-1:0] addr
);
   logic [FS_W-1:0] rst_word;
   logic [FS_W-1:0] first_word;

   always_comb begin
      rst_word         = '0;
      rst_word[FS_RSV] = 1'b1;
      first_word          = rst_word;
      first_word[FS_ERR]  = 1'b1;
      first_word[FS_LE]   = 1'b1;
      first_word[FS_FAV]  = 1'b1;
      first_word[FS_RD]   = log_read;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= rst_word;
         addr   <= '0;
      end else if (log_en) begin
         if (status[FS_FAV]) begin
            status[FS_ME] <= 1'b1;
         end else begin
            status <= first_word;
            addr   <= log_addr;
         end
      end
   end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
   import dvma_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PA_W       = 36,
   parameter int PTE_W      = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int NSLOT      = 4,
   parameter bit BYPASS_EN  = 1'b1,
   localparam int SLOT_W    = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_addr,
   input  logic              req_write,
   input  logic [SLOT_W-1:0] req_slot,
   input  logic [VA_W-1:0]   win_start,
   input  logic [VA_W-1:0]   pt_base,
   input  logic [NSLOT-1:0]  slot_bypass,
   input  logic [NSLOT-1:0]  slot_hi30,
   output logic              pte_req_valid,
   input  logic              pte_req_ready,
   output logic [VA_W-1:0]   pte_req_addr,
   input  logic              pte_rsp_valid,
   input  logic [PTE_W-1:0]  pte_rsp_data,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [PA_W-1:0]   rsp_pa,
   output logic              rsp_cache,
   input  logic              rsp_ack,
   output logic [31:0]       fault_status,
   output logic [VA_W-1:0]   fault_addr
);
   localparam int PPN_W     = PA_W - PAGE_SHIFT;
   localparam int PTE_BYTES = PTE_W / 8;

   generate
      if (PPN_W > PTE_W - 8) begin : g_chk_ppn
         $error("page number does not fit above the entry flags");
      end
      if (VA_W > PA_W || VA_W < 31) begin : g_chk_va
         $error("virtual width must be 31..PA_W");
      end
      if (NSLOT < 2 || (1 << SLOT_W) != NSLOT) begin : g_chk_slot
         $error("slot count must be a power of two >= 2");
      end
      if (PTE_W % 8 != 0) begin : g_chk_pte
         $error("entry width must be whole bytes");
      end
   endgenerate

   xlate_state_e      st_q;
   logic [VA_W-1:0]   addr_q;
   logic              write_q;
   logic [VA_W-1:0]   fetch_q;
   logic [PA_W-1:0]   pa_q;
   logic              err_q;
   logic              cache_q;

   logic              in_window;
   logic [VA_W-1:0]   pte_addr_c;
   logic              byp_hit;
   logic [PA_W-1:0]   byp_pa;
   logic              pte_ok;
   logic [PA_W-1:0]   pte_pa;
   logic              pte_cache;
   logic              accept;
   logic              log_en;
   logic              log_read;
   logic [VA_W-1:0]   log_addr;

   dvma_win_decode #(
      .VA_W       (VA_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .PTE_BYTES  (PTE_BYTES)
   ) u_win (
      .addr      (req_addr),
      .win_start (win_start),
      .pt_base   (pt_base),
      .in_window (in_window),
      .pte_addr  (pte_addr_c)
   );

   dvma_bypass_sel #(
      .VA_W      (VA_W),
      .PA_W      (PA_W),
      .NSLOT     (NSLOT),
      .HI_BIT    (30),
      .BYPASS_EN (BYPASS_EN)
   ) u_byp (
      .addr      (req_addr),
      .slot      (req_slot),
      .bypass_en (slot_bypass),
      .hi_en     (slot_hi30),
      .hit       (byp_hit),
      .pa        (byp_pa)
   );

   dvma_pte_eval #(
      .PA_W       (PA_W),
      .PTE_W      (PTE_W),
      .PAGE_SHIFT (PAGE_SHIFT)
   ) u_eval (
      .pte      (pte_rsp_data),
      .offset   (addr_q[PAGE_SHIFT-1:0]),
      .is_write (write_q),
      .ok       (pte_ok),
      .pa       (pte_pa),
      .cache    (pte_cache)
   );

   always_comb begin
      accept   = req_valid && (st_q == XS_IDLE);
      log_en   = 1'b0;
      log_read = 1'b0;
      log_addr = '0;
      if (accept && !byp_hit && !in_window) begin
         log_en   = 1'b1;
         log_read = !req_write;
         log_addr = req_addr;
      end else if (st_q == XS_WAIT && pte_rsp_valid && !pte_ok) begin
         log_en   = 1'b1;
         log_read = !write_q;
         log_addr = addr_q;
      end
   end

   dvma_fault_log #(
      .VA_W (VA_W),
      .FS_W (32)
   ) u_flog (
      .clk      (clk),
      .rst_n    (rst_n),
      .log_en   (log_en),
      .log_read (log_read),
      .log_addr (log_addr),
      .status   (fault_status),
      .addr     (fault_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= XS_IDLE;
         addr_q  <= '0;
         write_q <= 1'b0;
         fetch_q <= '0;
         pa_q    <= '0;
         err_q   <= 1'b0;
         cache_q <= 1'b0;
      end else begin
         case (st_q)
            XS_IDLE: if (accept) begin
               addr_q  <= req_addr;
               write_q <= req_write;
               if (byp_hit) begin
                  st_q    <= XS_DONE;
                  pa_q    <= byp_pa;
                  err_q   <= 1'b0;
                  cache_q <= 1'b0;
               end else if (!in_window) begin
                  st_q    <= XS_DONE;
                  pa_q    <= '0;
                  err_q   <= 1'b1;
                  cache_q <= 1'b0;
               end else begin
                  st_q    <= XS_FETCH;
                  fetch_q <= pte_addr_c;
               end
            end
            XS_FETCH: if (pte_req_ready) st_q <= XS_WAIT;
            XS_WAIT: if (pte_rsp_valid) begin
               st_q    <= XS_DONE;
               pa_q    <= pte_pa;
               err_q   <= !pte_ok;
               cache_q <= pte_cache;
            end
            XS_DONE: if (rsp_ack) st_q <= XS_IDLE;
            default: st_q <= XS_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready     = (st_q == XS_IDLE);
      pte_req_valid = (st_q == XS_FETCH);
      pte_req_addr  = fetch_q;
      rsp_done      = (st_q == XS_DONE);
      rsp_err       = err_q;
      rsp_pa        = pa_q;
      rsp_cache     = cache_q;
   end
endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk #(
   parameter int VA_W = 32,
   parameter int PA_W = 36
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            rsp_done,
   input logic            rsp_err,
   input logic            rsp_ack,
   input logic [PA_W-1:0] rsp_pa,
   input logic            rsp_cache,
   input logic            pte_req_valid,
   input logic            pte_req_ready,
   input logic [VA_W-1:0] pte_req_addr,
   input logic [31:0]     fault_status,
   input logic [VA_W-1:0] fault_addr
);
   assert_busy_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && rsp_done));

   assert_result_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !rsp_ack) |=> (rsp_done && $stable(rsp_pa) && $stable(rsp_err)
                                  && $stable(rsp_cache)));

   assert_fetch_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pte_req_valid && !pte_req_ready) |=> (pte_req_valid && $stable(pte_req_addr)));

   assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_err) |-> (rsp_pa == '0 && !rsp_cache));

   assert_rsv_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_status[23]);

   assert_fav_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_status[17] |=> (fault_status[17] && $stable(fault_addr)));

   assert_me_needs_fav_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_status[19] |-> fault_status[17]);
endmodule

bind dvma_xlate dvma_xlate_chk #(
   .VA_W (VA_W),
   .PA_W (PA_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_ready     (req_ready),
   .rsp_done      (rsp_done),
   .rsp_err       (rsp_err),
   .rsp_ack       (rsp_ack),
   .rsp_pa        (rsp_pa),
   .rsp_cache     (rsp_cache),
   .pte_req_valid (pte_req_valid),
   .pte_req_ready (pte_req_ready),
   .pte_req_addr  (pte_req_addr),
   .fault_status  (fault_status),
   .fault_addr    (fault_addr)
);

// File: tb/dvma_xlate_tb.sv
module dvma_xlate_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_slot = '0;
   logic [31:0] win_start = 32'hFF00_0000;
   logic [31:0] pt_base = 32'h1000_0000;
   logic [3:0]  slot_bypass = '0;
   logic [3:0]  slot_hi30 = '0;
   logic        pte_req_valid;
   logic        pte_req_ready;
   logic [31:0] pte_req_addr;
   logic        pte_rsp_valid = 1'b0;
   logic [31:0] pte_rsp_data = '0;
   logic        rsp_done;
   logic        rsp_err;
   logic [35:0] rsp_pa;
   logic        rsp_cache;
   logic        rsp_ack = 1'b0;
   logic [31:0] fault_status;
   logic [31:0] fault_addr;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   int fetch_cnt = 0;
   logic [31:0] last_fetch = '0;
   logic        pend = 1'b0;
   logic [31:0] exp_fs;
   logic [31:0] exp_fa;

   assign pte_req_ready = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   dvma_xlate dut_i (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .req_write (req_write), .req_slot (req_slot),
      .win_start (win_start), .pt_base (pt_base),
      .slot_bypass (slot_bypass), .slot_hi30 (slot_hi30),
      .pte_req_valid (pte_req_valid), .pte_req_ready (pte_req_ready),
      .pte_req_addr (pte_req_addr), .pte_rsp_valid (pte_rsp_valid),
      .pte_rsp_data (pte_rsp_data),
      .rsp_done (rsp_done), .rsp_err (rsp_err), .rsp_pa (rsp_pa),
      .rsp_cache (rsp_cache), .rsp_ack (rsp_ack),
      .fault_status (fault_status), .fault_addr (fault_addr)
   );

   // Bench page table: valid unless idx%4==3, writable when even, cacheable when idx%3==0
   function automatic logic [31:0] pte_fn(input logic [31:0] idx);
      logic [23:0] ppn;
      ppn = 24'(idx * 32'h1357 + 32'h0ABC);
      pte_fn = {ppn, 8'h00};
      pte_fn[7] = (idx % 3 == 0);
      pte_fn[2] = (idx % 2 == 0);
      pte_fn[1] = (idx % 4 != 3);
   endfunction

   // Entry server: one cycle to accept, data the following cycle
   always @(negedge clk) begin
      pte_rsp_valid <= 1'b0;
      if (pend) begin
         pte_rsp_valid <= 1'b1;
         pte_rsp_data  <= pte_fn((last_fetch - pt_base) >> 2);
         pend          <= 1'b0;
      end
      if (pte_req_valid) begin
         last_fetch <= pte_req_addr;
         fetch_cnt  <= fetch_cnt + 1;
         pend       <= 1'b1;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected<=%0d", cycles, WATCHDOG);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
      tests = tests + 1;
      if (act !== expv) begin
         fails = fails + 1;
         $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_fs = 32'h0080_0000;
      exp_fa = '0;
      check("R10 reset fault status", 64'(fault_status), 64'h0080_0000);
      check("R10 reset fault address", 64'(fault_addr), 64'h0);
      check("R10 reset ready", 64'(req_ready), 64'h1);
      check("R10 reset no result", 64'(rsp_done), 64'h0);
   endtask

   task automatic xact(input logic [31:0] a, input logic wr, input logic [1:0] s);
      logic [35:0] e_pa;
      logic        e_err;
      logic        e_cache;
      logic        e_fetch;
      logic [31:0] idx;
      logic [31:0] pte;
      logic        ok;
      int          f0;
      int          n;
      e_pa = '0; e_err = 1'b0; e_cache = 1'b0; e_fetch = 1'b0;
      idx = (a - win_start) >> 12;
      if (slot_bypass[s]) begin
         e_pa = {4'h0, a} | (slot_hi30[s] ? 36'h0_4000_0000 : 36'h0);
      end else if (a < win_start) begin
         e_err = 1'b1;
      end else begin
         e_fetch = 1'b1;
         pte = pte_fn(idx);
         ok = pte[1] && (!wr || pte[2]);
         e_err = !ok;
         e_pa = ok ? {pte[31:8], a[11:0]} : 36'h0;
         e_cache = ok && pte[7];
      end
      if (e_err) begin
         if (exp_fs[17]) exp_fs[19] = 1'b1;
         else begin
            exp_fs = wr ? 32'hC082_0000 : 32'hC086_0000;
            exp_fa = a;
         end
      end
      f0 = fetch_cnt;
      req_addr = a; req_write = wr; req_slot = s; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!rsp_done && n < 20) begin
         @(negedge clk);
         n++;
      end
      check("R11 result appears", 64'(rsp_done), 64'h1);
      check("R1 R4 R5 R7 physical address", 64'(rsp_pa), 64'(e_pa));
      check("R4 R5 R6 error flag", 64'(rsp_err), 64'(e_err));
      check("R3 cache hint", 64'(rsp_cache), 64'(e_cache));
      check("R6 R7 fetch count", 64'(fetch_cnt - f0), 64'(e_fetch));
      if (e_fetch)
         check("R2 fetch address", 64'(last_fetch), 64'(pt_base + idx * 4));
      check("R8 R9 fault status", 64'(fault_status), 64'(exp_fs));
      check("R8 R9 fault address", 64'(fault_addr), 64'(exp_fa));
      rsp_ack = 1'b1;
      @(negedge clk);
      rsp_ack = 1'b0;
      check("R11 released after ack", 64'({req_ready, rsp_done}), 64'h2);
   endtask

   initial begin
      do_reset();
      // Window of 16 MB, no bypass: all entry kinds, reads and writes
      win_start = 32'hFF00_0000;
      for (int pg = 0; pg < 16; pg++)
         for (int w = 0; w < 2; w++)
            xact(win_start + (pg << 12) + ((pg * 291 + w * 7) & 32'hFFF), w[0], 2'(pg % 4));
      xact(32'hFEFF_FFFC, 1'b0, 2'd1);   // R6 below window
      xact(32'hFEFF_F000, 1'b1, 2'd2);   // R6 below window, write

      // Fresh fault log, first fault is a read: R8 read encoding
      do_reset();
      xact(32'h0000_1234, 1'b0, 2'd3);
      xact(32'h0000_5678, 1'b1, 2'd3);   // R9

      // Window of 32 MB with bypass on slots 0 and 2, bit-30 option on slots 1 and 2
      do_reset();
      win_start   = 32'hFE00_0000;
      slot_bypass = 4'b0101;
      slot_hi30   = 4'b0110;
      for (int pg = 0; pg < 16; pg++)
         for (int w = 0; w < 2; w++)
            xact(win_start + (pg << 12) + ((pg * 173 + w * 13) & 32'hFFF), w[0], 2'(pg % 4));
      xact(32'h0012_3456, 1'b1, 2'd0);   // R7 bypass below window
      xact(32'h0012_3456, 1'b0, 2'd2);   // R7 bypass with bit 30
      xact(32'h0012_3456, 1'b0, 2'd1);   // R6 translated slot below window

      // R11 hold: result stays while ack is withheld, new request ignored
      slot_bypass = 4'b0000;
      req_addr = 32'hFE00_2010; req_write = 1'b0; req_slot = 2'd1; req_valid = 1'b1;
      @(negedge clk);
      req_addr = 32'hFE00_0000;
      repeat (3) @(negedge clk);
      check("R11 result shown", 64'(rsp_done), 64'h1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R11 held without ack", 64'({rsp_done, req_ready}), 64'h2);
         check("R11 address steady", 64'(rsp_pa),
               64'({pte_fn(32'd2) >> 8, 12'h010}));
      end
      req_valid = 1'b0;
      rsp_ack = 1'b1;
      @(negedge clk);
      rsp_ack = 1'b0;
      check("R11 idle after ack", 64'({req_ready, rsp_done}), 64'h2);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule